// File: doc/BRIEF.md
# APB Ingress Address Remapper

This block guards the entry of a per-channel configuration port. Every APB transaction that arrives on its upstream slave port has its address compared against two programmable windows. The first window that contains the address turns it into a local offset, `(address - base) + remap`, and the transaction is forwarded on the downstream APB master port with that offset. An address that falls in no window is refused with an error response and never reaches the downstream side.

The outgoing transaction carries a 9-bit target block identifier. By default this is copied from the upstream side. When an override is enabled, a programmed value replaces it. Two further controls protect the port. A response timer abandons a downstream access that stalls too long. A gate lets software stop new traffic and then confirm that the port is idle.

Only one transaction is in flight at a time. The controls sit behind a small APB register port of their own. Register offsets are byte addresses on that port:

| Offset | Register |
|---|---|
| 0x28 | Gate request, bit 0 |
| 0x2C | Drained status, read-only, bit 0 |
| 0x30 + 12·i + {0, 4, 8} | Base, size and remap of window i |
| 0x48 | Override (enable in bit 0, identifier in bits 9:1) |
| 0x8C | Timeout limit |

Top module: `apb_ingress_remap`

## Requirements
- R1: Window i matches an upstream address A when base ≤ A < base + size, with the sum evaluated without 32-bit wraparound. The forwarded address is (A − base) + remap, modulo 2^32.
- R2: A window whose size register is zero never matches.
- R3: When both windows match, window 0 (registers at 0x30..0x38) is used and window 1 (0x3C..0x44) is not.
- R4: When no window matches, the upstream transaction completes with pslverr = 1 and prdata = 0, and no downstream transaction is started.
- R5: Register 0x48 holds the override: bit 0 is the enable and bits 9:1 are the replacement identifier. With the enable set, m_blkid equals that identifier. With it clear, m_blkid equals s_blkid.
- R6: On a match, pwrite and pwdata are forwarded unchanged. The downstream pslverr is returned upstream. prdata is returned on success and reads 0 on any error.
- R7: The timeout limit register is at 0x8C and resets to 0x2000. With a nonzero limit L, the downstream side is given at most L access-phase cycles. If pready is not seen by then, m_psel is dropped and the upstream transaction completes with pslverr = 1 and prdata = 0.
- R8: A timeout limit of zero disables the timeout, so a downstream access may wait any number of cycles.
- R9: A downstream pready that arrives after a timeout is ignored. It produces no upstream response and does not disturb the next transaction.
- R10: While bit 0 of 0x28 is set, no new upstream transaction is forwarded or answered. Bit 0 of 0x2C reads 1 exactly when the gate is set and no transaction is in flight.
- R11: All window registers, the override and the timeout limit read back the full word last written. Window registers reset to 0.
- R12: Each downstream transfer has exactly one setup cycle, followed by access cycles with m_paddr held stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_psel | input | 1 | Upstream select |
| s_penable | input | 1 | Upstream enable |
| s_pwrite | input | 1 | Upstream write strobe |
| s_paddr | input | 32 | Upstream address |
| s_pwdata | input | 32 | Upstream write data |
| s_blkid | input | 9 | Upstream target block identifier |
| s_prdata | output | 32 | Upstream read data |
| s_pready | output | 1 | Upstream ready |
| s_pslverr | output | 1 | Upstream error |
| m_psel | output | 1 | Downstream select |
| m_penable | output | 1 | Downstream enable |
| m_pwrite | output | 1 | Downstream write strobe |
| m_paddr | output | 32 | Remapped downstream address |
| m_pwdata | output | 32 | Downstream write data |
| m_blkid | output | 9 | Downstream target block identifier |
| m_prdata | input | 32 | Downstream read data |
| m_pready | input | 1 | Downstream ready |
| m_pslverr | input | 1 | Downstream error |
| c_psel | input | 1 | Control port select |
| c_penable | input | 1 | Control port enable |
| c_pwrite | input | 1 | Control port write strobe |
| c_paddr | input | 8 | Control port byte address |
| c_pwdata | input | 32 | Control port write data |
| c_prdata | output | 32 | Control port read data |
| c_pready | output | 1 | Control port ready |

## Verification
The remapper is driven with random window sets, some of them overlapping and some with zero size, and with addresses clustered around the window edges. These patterns separate a correct priority and range check from an off-by-one or wrongly ordered comparison. Directed cases cover:
- a window that ends past 2^32;
- the exact edges of both windows;
- downstream wait counts of one below and exactly at the timeout limit;
- a late ready pulse after a timeout.

These cases separate a timer that allows L access cycles from one that allows L − 1 or L + 1. The gate is checked with a transaction left pending while the gate is set, which shows that nothing leaks through before the gate is released.

// File: rtl/apbr_pkg.sv
package apbr_pkg;
  typedef enum logic [1:0] {
    XS_IDLE,
    XS_SETUP,
    XS_ACCESS,
    XS_RESP
  } xfer_state_e;

  // Control port byte offsets
  localparam int unsigned OFS_GATE   = 32'h28;
  localparam int unsigned OFS_DRAIN  = 32'h2C;
  localparam int unsigned OFS_WIN0   = 32'h30;
  localparam int unsigned WIN_STRIDE = 12;
  localparam int unsigned OFS_TMO    = 32'h8C;
endpackage

// File: rtl/apbr_cfg_regs.sv
module apbr_cfg_regs
  import apbr_pkg::*;
#(
  parameter int W         = 32,
  parameter int NUM_WIN   = 2,
  parameter int BID_W     = 9,
  parameter int TMO_W     = 32,
  parameter int CFG_AW    = 8,
  parameter int TMO_RESET = 32'h2000
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          c_psel,
  input  logic                          c_penable,
  input  logic                          c_pwrite,
  input  logic [CFG_AW-1:0]             c_paddr,
  input  logic [W-1:0]                  c_pwdata,
  output logic [W-1:0]                  c_prdata,
  output logic                          c_pready,
  input  logic                          drained,
  output logic                          gate_req,
  output logic [NUM_WIN-1:0][W-1:0]     win_base,
  output logic [NUM_WIN-1:0][W-1:0]     win_size,
  output logic [NUM_WIN-1:0][W-1:0]     win_remap,
  output logic                          ovr_en,
  output logic [BID_W-1:0]              ovr_id,
  output logic [TMO_W-1:0]              tmo_limit
);
  localparam int unsigned OFS_OVR = OFS_WIN0 + WIN_STRIDE * NUM_WIN;
  localparam logic [CFG_AW-1:0] A_GATE  = CFG_AW'(OFS_GATE);
  localparam logic [CFG_AW-1:0] A_DRAIN = CFG_AW'(OFS_DRAIN);
  localparam logic [CFG_AW-1:0] A_OVR   = CFG_AW'(OFS_OVR);
  localparam logic [CFG_AW-1:0] A_TMO   = CFG_AW'(OFS_TMO);

  logic [W-1:0] gate_w;
  logic [W-1:0] ovr_w;
  logic         wr_en;
  logic [W-1:0] rd_val;

  assign wr_en    = c_psel && c_penable && c_pwrite;
  assign c_pready = 1'b1;
  assign gate_req = gate_w[0];
  assign ovr_en   = ovr_w[0];
  assign ovr_id   = ovr_w[BID_W:1];

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_w    <= '0;
      ovr_w     <= '0;
      tmo_limit <= TMO_W'(TMO_RESET);
      win_base  <= '0;
      win_size  <= '0;
      win_remap <= '0;
    end else if (wr_en) begin
      if (c_paddr == A_GATE) gate_w <= c_pwdata;
      if (c_paddr == A_OVR)  ovr_w  <= c_pwdata;
      if (c_paddr == A_TMO)  tmo_limit <= c_pwdata[TMO_W-1:0];
      for (int i = 0; i < NUM_WIN; i++) begin
        if (c_paddr == CFG_AW'(OFS_WIN0 + WIN_STRIDE * i))     win_base[i]  <= c_pwdata;
        if (c_paddr == CFG_AW'(OFS_WIN0 + WIN_STRIDE * i + 4)) win_size[i]  <= c_pwdata;
        if (c_paddr == CFG_AW'(OFS_WIN0 + WIN_STRIDE * i + 8)) win_remap[i] <= c_pwdata;
      end
    end
  end

  always_comb begin
    rd_val = '0;
    if (c_paddr == A_GATE)  rd_val = gate_w;
    if (c_paddr == A_DRAIN) rd_val = W'(drained);
    if (c_paddr == A_OVR)   rd_val = ovr_w;
    if (c_paddr == A_TMO)   rd_val = W'(tmo_limit);
    for (int i = 0; i < NUM_WIN; i++) begin
      if (c_paddr == CFG_AW'(OFS_WIN0 + WIN_STRIDE * i))     rd_val = win_base[i];
      if (c_paddr == CFG_AW'(OFS_WIN0 + WIN_STRIDE * i + 4)) rd_val = win_size[i];
      if (c_paddr == CFG_AW'(OFS_WIN0 + WIN_STRIDE * i + 8)) rd_val = win_remap[i];
    end
  end

  // Read data is captured in the setup phase, valid in the access phase
  always_ff @(posedge clk) begin
    if (rst)                        c_prdata <= '0;
    else if (c_psel && !c_penable)  c_prdata <= rd_val;
  end
endmodule

// File: rtl/apbr_win_decode.sv
module apbr_win_decode #(
  parameter int W       = 32,
  parameter int NUM_WIN = 2
) (
  input  logic [W-1:0]              addr,
  input  logic [NUM_WIN-1:0][W-1:0] win_base,
  input  logic [NUM_WIN-1:0][W-1:0] win_size,
  input  logic [NUM_WIN-1:0][W-1:0] win_remap,
  output logic                      hit,
  output logic [W-1:0]              out_addr
);
  logic [NUM_WIN-1:0]        hit_v;
  logic [NUM_WIN-1:0][W-1:0] xl_v;

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    logic [W:0] lo_ext;
    logic [W:0] hi_ext;
    logic [W:0] a_ext;
    assign a_ext    = {1'b0, addr};
    assign lo_ext   = {1'b0, win_base[g]};
    assign hi_ext   = lo_ext + {1'b0, win_size[g]};
    assign hit_v[g] = (win_size[g] != '0) && (a_ext >= lo_ext) && (a_ext < hi_ext);
    assign xl_v[g]  = (addr - win_base[g]) + win_remap[g];
  end

  // Lowest-numbered matching window wins
  always_comb begin
    hit      = 1'b0;
    out_addr = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hit_v[i]) begin
        hit      = 1'b1;
        out_addr = xl_v[i];
      end
    end
  end
endmodule

// File: rtl/apbr_xfer_ctl.sv
module apbr_xfer_ctl
  import apbr_pkg::*;
#(
  parameter int W     = 32,
  parameter int BID_W = 9,
  parameter int TMO_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             s_psel,
  input  logic             s_pwrite,
  input  logic [W-1:0]     s_pwdata,
  output logic [W-1:0]     s_prdata,
  output logic             s_pready,
  output logic             s_pslverr,
  input  logic             dec_hit,
  input  logic [W-1:0]     dec_addr,
  input  logic [BID_W-1:0] bid_sel,
  input  logic             gate_req,
  input  logic [TMO_W-1:0] tmo_limit,
  output logic             idle,
  output logic             m_psel,
  output logic             m_penable,
  output logic             m_pwrite,
  output logic [W-1:0]     m_paddr,
  output logic [W-1:0]     m_pwdata,
  output logic [BID_W-1:0] m_blkid,
  input  logic [W-1:0]     m_prdata,
  input  logic             m_pready,
  input  logic             m_pslverr
);
  xfer_state_e      state;
  logic [TMO_W-1:0] wait_cnt;
  logic             tmo_hit;

  assign idle    = (state == XS_IDLE);
  assign tmo_hit = (tmo_limit != '0) && (wait_cnt == tmo_limit - TMO_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= XS_IDLE;
      wait_cnt  <= '0;
      s_prdata  <= '0;
      s_pready  <= 1'b0;
      s_pslverr <= 1'b0;
      m_psel    <= 1'b0;
      m_penable <= 1'b0;
      m_pwrite  <= 1'b0;
      m_paddr   <= '0;
      m_pwdata  <= '0;
      m_blkid   <= '0;
    end else begin
      s_pready <= 1'b0;
      unique case (state)
        XS_IDLE: begin
          if (s_psel && !gate_req) begin
            if (dec_hit) begin
              m_psel   <= 1'b1;
              m_paddr  <= dec_addr;
              m_pwrite <= s_pwrite;
              m_pwdata <= s_pwdata;
              m_blkid  <= bid_sel;
              state    <= XS_SETUP;
            end else begin
              s_pready  <= 1'b1;
              s_pslverr <= 1'b1;
              s_prdata  <= '0;
              state     <= XS_RESP;
            end
          end
        end
        XS_SETUP: begin
          m_penable <= 1'b1;
          wait_cnt  <= '0;
          state     <= XS_ACCESS;
        end
        XS_ACCESS: begin
          if (m_pready) begin
            m_psel    <= 1'b0;
            m_penable <= 1'b0;
            s_pready  <= 1'b1;
            s_pslverr <= m_pslverr;
            s_prdata  <= m_pslverr ? '0 : m_prdata;
            state     <= XS_RESP;
          end else if (tmo_hit) begin
            m_psel    <= 1'b0;
            m_penable <= 1'b0;
            s_pready  <= 1'b1;
            s_pslverr <= 1'b1;
            s_prdata  <= '0;
            state     <= XS_RESP;
          end else begin
            wait_cnt <= wait_cnt + TMO_W'(1);
          end
        end
        XS_RESP: begin
          state <= XS_IDLE;
        end
        default: state <= XS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/apb_ingress_remap.sv
module apb_ingress_remap #(
  parameter int W         = 32,
  parameter int NUM_WIN   = 2,
  parameter int BID_W     = 9,
  parameter int TMO_W     = 32,
  parameter int CFG_AW    = 8,
  parameter int TMO_RESET = 32'h2000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s_psel,
  input  logic              s_penable,
  input  logic              s_pwrite,
  input  logic [W-1:0]      s_paddr,
  input  logic [W-1:0]      s_pwdata,
  input  logic [BID_W-1:0]  s_blkid,
  output logic [W-1:0]      s_prdata,
  output logic              s_pready,
  output logic              s_pslverr,
  output logic              m_psel,
  output logic              m_penable,
  output logic              m_pwrite,
  output logic [W-1:0]      m_paddr,
  output logic [W-1:0]      m_pwdata,
  output logic [BID_W-1:0]  m_blkid,
  input  logic [W-1:0]      m_prdata,
  input  logic              m_pready,
  input  logic              m_pslverr,
  input  logic              c_psel,
  input  logic              c_penable,
  input  logic              c_pwrite,
  input  logic [CFG_AW-1:0] c_paddr,
  input  logic [W-1:0]      c_pwdata,
  output logic [W-1:0]      c_prdata,
  output logic              c_pready
);
  logic                      gate_req;
  logic                      drained;
  logic                      xfer_idle;
  logic [NUM_WIN-1:0][W-1:0] win_base;
  logic [NUM_WIN-1:0][W-1:0] win_size;
  logic [NUM_WIN-1:0][W-1:0] win_remap;
  logic                      ovr_en;
  logic [BID_W-1:0]          ovr_id;
  logic [TMO_W-1:0]          tmo_limit;
  logic                      dec_hit;
  logic [W-1:0]              dec_addr;
  logic [BID_W-1:0]          bid_sel;
  logic                      s_penable_unused;

  // Phase tracking is done by the transfer FSM; enable is not needed to accept
  assign s_penable_unused = s_penable;
  assign drained = gate_req && xfer_idle;
  assign bid_sel = ovr_en ? ovr_id : s_blkid;

  apbr_cfg_regs #(
    .W(W), .NUM_WIN(NUM_WIN), .BID_W(BID_W), .TMO_W(TMO_W),
    .CFG_AW(CFG_AW), .TMO_RESET(TMO_RESET)
  ) u_regs (
    .clk(clk), .rst(rst),
    .c_psel(c_psel), .c_penable(c_penable), .c_pwrite(c_pwrite),
    .c_paddr(c_paddr), .c_pwdata(c_pwdata), .c_prdata(c_prdata), .c_pready(c_pready),
    .drained(drained), .gate_req(gate_req),
    .win_base(win_base), .win_size(win_size), .win_remap(win_remap),
    .ovr_en(ovr_en), .ovr_id(ovr_id), .tmo_limit(tmo_limit)
  );

  apbr_win_decode #(.W(W), .NUM_WIN(NUM_WIN)) u_dec (
    .addr(s_paddr), .win_base(win_base), .win_size(win_size), .win_remap(win_remap),
    .hit(dec_hit), .out_addr(dec_addr)
  );

  apbr_xfer_ctl #(.W(W), .BID_W(BID_W), .TMO_W(TMO_W)) u_xfer (
    .clk(clk), .rst(rst),
    .s_psel(s_psel), .s_pwrite(s_pwrite), .s_pwdata(s_pwdata),
    .s_prdata(s_prdata), .s_pready(s_pready), .s_pslverr(s_pslverr),
    .dec_hit(dec_hit), .dec_addr(dec_addr), .bid_sel(bid_sel),
    .gate_req(gate_req), .tmo_limit(tmo_limit), .idle(xfer_idle),
    .m_psel(m_psel), .m_penable(m_penable), .m_pwrite(m_pwrite),
    .m_paddr(m_paddr), .m_pwdata(m_pwdata), .m_blkid(m_blkid),
    .m_prdata(m_prdata), .m_pready(m_pready), .m_pslverr(m_pslverr)
  );
endmodule

// File: rtl/apbr_checker.sv
module apbr_checker #(
  parameter int W     = 32,
  parameter int BID_W = 9,
  parameter int TMO_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             m_psel,
  input logic             m_penable,
  input logic             m_pready,
  input logic [W-1:0]     m_paddr,
  input logic [BID_W-1:0] m_blkid,
  input logic             s_pready,
  input logic             s_pslverr,
  input logic [W-1:0]     s_prdata,
  input logic             gate_req,
  input logic             drained,
  input logic             ovr_en,
  input logic [BID_W-1:0] ovr_id,
  input logic [TMO_W-1:0] tmo_limit
);
  logic [TMO_W-1:0] acc_cnt;

  always_ff @(posedge clk) begin
    if (rst) acc_cnt <= '0;
    else if (m_psel && m_penable && !m_pready) acc_cnt <= acc_cnt + TMO_W'(1);
    else acc_cnt <= '0;
  end

  AST_SETUP_THEN_ACCESS: assert property (@(posedge clk) disable iff (rst)
    (m_psel && !m_penable) |=> (m_psel && m_penable)); // R12
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
    (m_psel && m_penable) |-> $stable(m_paddr)); // R12
  AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (rst)
    (s_pready && s_pslverr) |-> (s_prdata == '0)); // R4
  AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (rst)
    s_pready |=> !s_pready); // R6
  AST_GATE_NO_START: assert property (@(posedge clk) disable iff (rst)
    $rose(m_psel) |-> !$past(gate_req)); // R10
  AST_DRAIN_IDLE: assert property (@(posedge clk) disable iff (rst)
    drained |-> !m_psel); // R10
  AST_BLKID_OVR: assert property (@(posedge clk) disable iff (rst)
    ($rose(m_psel) && $past(ovr_en)) |-> (m_blkid == $past(ovr_id))); // R5
  AST_TMO_BOUND: assert property (@(posedge clk) disable iff (rst)
    (m_psel && m_penable && (tmo_limit != '0)) |-> (acc_cnt < tmo_limit)); // R7
endmodule

bind apb_ingress_remap apbr_checker #(.W(W), .BID_W(BID_W), .TMO_W(TMO_W)) u_chk (
  .clk(clk), .rst(rst),
  .m_psel(m_psel), .m_penable(m_penable), .m_pready(m_pready),
  .m_paddr(m_paddr), .m_blkid(m_blkid),
  .s_pready(s_pready), .s_pslverr(s_pslverr), .s_prdata(s_prdata),
  .gate_req(gate_req), .drained(drained),
  .ovr_en(ovr_en), .ovr_id(ovr_id), .tmo_limit(tmo_limit)
);

// File: tb/apb_ingress_remap_test.sv
module apb_ingress_remap_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        s_psel = 0, s_penable = 0, s_pwrite = 0;
  logic [31:0] s_paddr = 0, s_pwdata = 0;
  logic [8:0]  s_blkid = 0;
  logic [31:0] s_prdata;
  logic        s_pready, s_pslverr;
  logic        m_psel, m_penable, m_pwrite;
  logic [31:0] m_paddr, m_pwdata;
  logic [8:0]  m_blkid;
  logic [31:0] m_prdata = 0;
  logic        m_pready = 0, m_pslverr = 0;
  logic        c_psel = 0, c_penable = 0, c_pwrite = 0;
  logic [7:0]  c_paddr = 0;
  logic [31:0] c_pwdata = 0;
  logic [31:0] c_prdata;
  logic        c_pready;

  int tests = 0, fails = 0;
  int wait_n = 0, acc_seen = 0, late_cnt = 0;
  bit saw_fwd = 0;
  logic [31:0] cap_addr, cap_wdata;
  logic        cap_write;
  logic [8:0]  cap_bid;
  logic [31:0] sh_base[2], sh_size[2], sh_remap[2];
  bit          sh_ovr_en = 0;
  logic [8:0]  sh_ovr_id = 0;

  always #10 clk = ~clk;

  apb_ingress_remap uut (
    .clk(clk), .rst(rst),
    .s_psel(s_psel), .s_penable(s_penable), .s_pwrite(s_pwrite),
    .s_paddr(s_paddr), .s_pwdata(s_pwdata), .s_blkid(s_blkid),
    .s_prdata(s_prdata), .s_pready(s_pready), .s_pslverr(s_pslverr),
    .m_psel(m_psel), .m_penable(m_penable), .m_pwrite(m_pwrite),
    .m_paddr(m_paddr), .m_pwdata(m_pwdata), .m_blkid(m_blkid),
    .m_prdata(m_prdata), .m_pready(m_pready), .m_pslverr(m_pslverr),
    .c_psel(c_psel), .c_penable(c_penable), .c_pwrite(c_pwrite),
    .c_paddr(c_paddr), .c_pwdata(c_pwdata), .c_prdata(c_prdata), .c_pready(c_pready)
  );

  function automatic logic [31:0] resp_data(input logic [31:0] a);
    return a ^ 32'h5A5A_3C3C;
  endfunction

  function automatic bit resp_err(input logic [31:0] a);
    return a[3:0] == 4'hF;
  endfunction

  // Expected decode from the requirements (R1, R2, R3)
  function automatic bit exp_decode(input logic [31:0] a, output logic [31:0] o);
    o = 0;
    for (int i = 0; i < 2; i++) begin
      if (sh_size[i] != 0 && {1'b0, a} >= {1'b0, sh_base[i]} &&
          {1'b0, a} < ({1'b0, sh_base[i]} + {1'b0, sh_size[i]})) begin
        o = (a - sh_base[i]) + sh_remap[i];
        return 1;
      end
    end
    return 0;
  endfunction

  // Downstream responder model
  always @(negedge clk) begin
    if (late_cnt > 0) begin
      m_pready = 1; m_prdata = 32'hDEAD_BEEF; m_pslverr = 0;
      late_cnt = late_cnt - 1;
    end else if (m_psel && m_penable) begin
      if (acc_seen == 0) begin
        cap_addr = m_paddr; cap_write = m_pwrite; cap_wdata = m_pwdata; cap_bid = m_blkid;
      end
      saw_fwd = 1;
      if (acc_seen >= wait_n) begin
        m_pready = 1; m_prdata = resp_data(m_paddr); m_pslverr = resp_err(m_paddr);
      end else begin
        m_pready = 0;
      end
      acc_seen = acc_seen + 1;
    end else begin
      m_pready = 0; m_pslverr = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); c_psel = 1; c_penable = 0; c_pwrite = 1; c_paddr = a; c_pwdata = d;
    @(negedge clk); c_penable = 1;
    @(negedge clk); c_psel = 0; c_penable = 0; c_pwrite = 0;
  endtask

  task automatic cfg_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); c_psel = 1; c_penable = 0; c_pwrite = 0; c_paddr = a;
    @(negedge clk); c_penable = 1; d = c_prdata;
    @(negedge clk); c_psel = 0; c_penable = 0;
  endtask

  task automatic set_win(input int i, input logic [31:0] b, input logic [31:0] s,
                         input logic [31:0] r);
    sh_base[i] = b; sh_size[i] = s; sh_remap[i] = r;
    cfg_wr(8'(8'h30 + 12 * i), b);
    cfg_wr(8'(8'h34 + 12 * i), s);
    cfg_wr(8'(8'h38 + 12 * i), r);
  endtask

  task automatic set_ovr(input bit en, input logic [8:0] id);
    sh_ovr_en = en; sh_ovr_id = id;
    cfg_wr(8'h48, {22'b0, id, en});
  endtask

  task automatic up_xfer(input logic [31:0] a, input bit wr, input logic [31:0] wd,
                         input logic [8:0] bid, output logic [31:0] rd, output bit err);
    bit done = 0;
    acc_seen = 0; saw_fwd = 0; rd = 0; err = 0;
    @(negedge clk); s_psel = 1; s_penable = 0; s_paddr = a; s_pwrite = wr;
    s_pwdata = wd; s_blkid = bid;
    @(negedge clk); s_penable = 1;
    for (int k = 0; k < 400 && !done; k++) begin
      if (s_pready) begin done = 1; rd = s_prdata; err = s_pslverr; end
      else @(negedge clk);
    end
    s_psel = 0; s_penable = 0;
    chk(done, "R6", "upstream transaction completed", 32'(done), 1);
  endtask

  // Full check of one transaction against the requirements
  task automatic run_one(input logic [31:0] a, input bit wr, input logic [31:0] wd,
                         input logic [8:0] bid, input string req);
    logic [31:0] rd, ea;
    bit err, hit;
    hit = exp_decode(a, ea);
    up_xfer(a, wr, wd, bid, rd, err);
    if (hit) begin
      chk(saw_fwd, req, "forwarded on match", 32'(saw_fwd), 1);
      chk(cap_addr == ea, req, "remapped address", cap_addr, ea);
      chk(cap_write == wr, "R6", "pwrite forwarded", 32'(cap_write), 32'(wr));
      if (wr) chk(cap_wdata == wd, "R6", "pwdata forwarded", cap_wdata, wd);
      chk(cap_bid == (sh_ovr_en ? sh_ovr_id : bid), "R5", "block id", 32'(cap_bid),
          32'(sh_ovr_en ? sh_ovr_id : bid));
      chk(err == resp_err(ea), "R6", "pslverr returned", 32'(err), 32'(resp_err(ea)));
      chk(rd == (resp_err(ea) ? 32'h0 : resp_data(ea)), "R6", "prdata returned", rd,
          resp_err(ea) ? 32'h0 : resp_data(ea));
    end else begin
      chk(!saw_fwd, "R4", "no forward on miss", 32'(saw_fwd), 0);
      chk(err && rd == 0, "R4", "error and zero data on miss", {rd[30:0], err}, 1);
    end
  endtask

  initial begin
    #(20 * 150000);
    tests++; fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] d, rd;
    bit err;
    for (int i = 0; i < 2; i++) begin sh_base[i] = 0; sh_size[i] = 0; sh_remap[i] = 0; end
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!s_pready && !m_psel, "R11", "idle outputs after reset", {m_psel, s_pready}, 0);
    cfg_rd(8'h8C, d); chk(d == 32'h2000, "R7", "timeout limit reset", d, 32'h2000);
    cfg_rd(8'h30, d); chk(d == 0, "R11", "window base reset", d, 0);
    cfg_rd(8'h40, d); chk(d == 0, "R11", "window size reset", d, 0);
    cfg_rd(8'h2C, d); chk(d == 0, "R10", "drained clear without gate", d, 0);
    run_one(32'h100, 0, 0, 9'h3, "R2");  // all windows disabled at reset

    // R11 readback
    set_win(0, 32'h100, 32'h100, 32'hA0000);
    set_win(1, 32'h180, 32'h100, 32'hB0000);
    cfg_rd(8'h38, d); chk(d == 32'hA0000, "R11", "window 0 remap readback", d, 32'hA0000);
    cfg_rd(8'h3C, d); chk(d == 32'h180, "R11", "window 1 base readback", d, 32'h180);
    cfg_rd(8'h40, d); chk(d == 32'h100, "R11", "window 1 size readback", d, 32'h100);

    // R1 edges and R3 priority
    run_one(32'h100, 0, 0, 9'h11, "R1");
    run_one(32'hFF,  0, 0, 9'h11, "R1");
    run_one(32'h1C0, 1, 32'h1234_5678, 9'h12, "R3");
    run_one(32'h220, 0, 0, 9'h13, "R1");
    run_one(32'h27F, 0, 0, 9'h13, "R1");
    run_one(32'h280, 0, 0, 9'h13, "R1");
    // R2: window 0 disabled, overlap now goes to window 1
    set_win(0, 32'h100, 32'h0, 32'hA0000);
    run_one(32'h1C0, 0, 0, 9'h14, "R2");
    run_one(32'h100, 0, 0, 9'h14, "R2");
    // R1: window crossing 2^32 does not wrap
    set_win(1, 32'hFFFF_FF00, 32'h200, 32'h10);
    run_one(32'hFFFF_FFFF, 1, 32'hCAFE, 9'h15, "R1");
    run_one(32'h0000_0050, 0, 0, 9'h15, "R1");

    // R5 override
    set_win(0, 32'h4000, 32'h1000, 32'h0);
    cfg_wr(8'h48, {22'b0, 9'h1AB, 1'b1}); sh_ovr_en = 1; sh_ovr_id = 9'h1AB;
    cfg_rd(8'h48, d); chk(d == 32'h357, "R11", "override readback", d, 32'h357);
    run_one(32'h4010, 0, 0, 9'h022, "R5");
    set_ovr(0, 9'h0);
    run_one(32'h4020, 0, 0, 9'h0C3, "R5");

    // R7 timeout boundary
    cfg_wr(8'h8C, 32'd5);
    wait_n = 4;
    up_xfer(32'h4100, 0, 0, 0, rd, err);
    chk(!err && rd == resp_data(32'h100), "R7", "response at last allowed cycle", rd,
        resp_data(32'h100));
    chk(acc_seen == 5, "R7", "access cycles at limit", 32'(acc_seen), 5);
    wait_n = 5;
    up_xfer(32'h4104, 0, 0, 0, rd, err);
    chk(err && rd == 0, "R7", "timeout gives error and zero data", {rd[30:0], err}, 1);
    chk(acc_seen == 5, "R7", "access cycles before abort", 32'(acc_seen), 5);
    chk(!m_psel, "R7", "downstream select dropped", 32'(m_psel), 0);
    // R9 late response ignored
    late_cnt = 3;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(!s_pready, "R9", "late ready not reflected upstream", 32'(s_pready), 0);
    end
    wait_n = 1;
    run_one(32'h4200, 0, 0, 9'h7, "R9");
    // R8 limit zero
    cfg_wr(8'h8C, 32'd0);
    wait_n = 40;
    up_xfer(32'h4300, 0, 0, 0, rd, err);
    chk(!err && rd == resp_data(32'h300), "R8", "long wait with timeout off", rd,
        resp_data(32'h300));
    chk(acc_seen == 41, "R8", "all wait cycles granted", 32'(acc_seen), 41);
    cfg_wr(8'h8C, 32'h2000);

    // R10 gate and drain
    wait_n = 0;
    cfg_wr(8'h28, 32'h1);
    cfg_rd(8'h2C, d); chk(d == 1, "R10", "drained when gated and idle", d, 1);
    acc_seen = 0; saw_fwd = 0;
    @(negedge clk); s_psel = 1; s_penable = 0; s_paddr = 32'h4400; s_pwrite = 0;
    @(negedge clk); s_penable = 1;
    begin
      bit leak = 0, done = 0;
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        if (s_pready || saw_fwd) leak = 1;
      end
      chk(!leak, "R10", "nothing forwarded while gated", 32'(leak), 0);
      cfg_wr(8'h28, 32'h0);
      for (int k = 0; k < 50 && !done; k++) begin
        if (s_pready) begin done = 1; rd = s_prdata; end
        else @(negedge clk);
      end
      s_psel = 0; s_penable = 0;
      chk(done && rd == resp_data(32'h400), "R10", "completes after ungate", rd,
          resp_data(32'h400));
    end
    cfg_rd(8'h2C, d); chk(d == 0, "R10", "drained clear after ungate", d, 0);

    // Random rounds with overlapping windows near edges
    for (int r = 0; r < 4; r++) begin
      for (int w = 0; w < 2; w++)
        set_win(w, 32'h1000_0000 + ($urandom % 32'h400),
                (r == 1 && w == 0) ? 32'h0 : ($urandom % 32'h200) + 1, $urandom);
      set_ovr(r[0], 9'($urandom));
      for (int t = 0; t < 40; t++) begin
        logic [31:0] a;
        wait_n = $urandom % 4;
        a = 32'h1000_0000 + ($urandom % 32'h800);
        if (t % 5 == 0) a = sh_base[t % 2] + sh_size[t % 2] - (t % 10 == 0 ? 0 : 1);
        run_one(a, $urandom % 2, $urandom, 9'($urandom), "R1");
      end
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule